// File: doc/BRIEF.md
# 64-bit Lightweight Block Encryptor (80-bit key)

This block encrypts one 64-bit data word under an 80-bit key with a substitution-permutation cipher of 31 rounds. A one-cycle `start` pulse loads the plaintext and key from parallel ports. After that, the block computes one round on every clock. The round datapath and the key update work in parallel, so no round keys are stored.

Each round has three steps in order: XOR with a round key, a layer of sixteen 4-bit S-boxes, and a fixed bit permutation. The round key is taken from the key register, which is updated on the fly. After the last round, one more cycle XORs in the final round key and registers the ciphertext.

The result appears on `cipher_out` with `done` set. Both hold until the next accepted start. The block is meant to sit inside a larger design that supplies the key directly.

Top module: `lwc64_encrypt`

## Requirements
- R1: Reset (active-low `rst_n`) gives `busy`=0, `done`=0 and `cipher_out`=0.
- R2: A `start` sampled high while `busy`=0 captures `plain_in` and `key_in` on that edge. It sets `busy`=1 and clears `done` from the next cycle.
- R3: `done` rises after the 32nd rising edge, counting the edge that sampled `start`. `busy` stays high for the 31 cycles in between and falls in the same cycle that `done` rises.
- R4: The ciphertext is computed as follows. For rounds r=1..31, the state is XORed with round key K_r, then passed through the S-box layer, then through the permutation. The result is then XORed with K_32.
- R5: Round key K_r is bits 79:16 of the key register in round r. The register starts as the user key. After round r it is updated in three steps, in this order:
  - rotate so that the new bits 79..0 are the old bits 18..0 followed by the old bits 79..19;
  - replace bits 79:76 with the S-box of those bits;
  - XOR bits 19:15 with the 5-bit value r.
- R6: The S-box maps inputs 0..F to C,5,6,B,9,0,A,D,3,E,F,8,4,7,1,2. It is applied to every nibble, where nibble i is state bits 4i+3..4i.
- R7: The permutation moves state bit i to bit (16·i mod 63) for i=0..62. Bit 63 stays in place.
- R8: Plaintext 0 under key 0 gives 5579C1387B228445. Plaintext 0 under the all-ones key gives E72C46C0F5945049.
- R9: A `start` while `busy`=1 is ignored. The running block still completes with its original ciphertext and latency.
- R10: `done` and `cipher_out` hold their values while `start` stays low after completion.
- R11: `cipher_out` changes only in the cycle in which `done` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Load-and-go strobe, accepted when idle |
| plain_in | input | 64 | Plaintext, sampled with an accepted start |
| key_in | input | 80 | Cipher key, sampled with an accepted start |
| busy | output | 1 | Rounds in progress |
| done | output | 1 | Ciphertext valid, held until the next accepted start |
| cipher_out | output | 64 | Registered ciphertext |

## Verification
The hardest case to reach is a `start` that arrives while the rounds are running. To be ignored correctly, it must not disturb the round counter, the key register or the state mid-schedule. The stimulus pulses `start` with different plaintext and key at chosen round positions, including the first and last busy cycles. It then compares the finished ciphertext with the first block's expected value and rechecks the latency.

A second hard case is a restart on the very cycle after `done` rises. Back-to-back blocks exercise that path.

Random plaintext and key pairs from a fixed seed cover the S-box, permutation and key-rotation wiring, together with the all-zero and all-one vectors.

// File: rtl/lwc_pkg.sv
package lwc_pkg;

    localparam int BLK_W  = 64;
    localparam int KEY_W  = 80;
    localparam int NIB_W  = 4;
    localparam int NIBS   = BLK_W / NIB_W;
    localparam int RK_LSB = KEY_W - BLK_W;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_RUN   = 2'd1,
        PH_FINAL = 2'd2
    } phase_e;

    // 4-bit substitution
    function automatic logic [NIB_W-1:0] sub4(input logic [NIB_W-1:0] x);
        logic [NIB_W-1:0] y;
        case (x)
            4'h0: y = 4'hC;
            4'h1: y = 4'h5;
            4'h2: y = 4'h6;
            4'h3: y = 4'hB;
            4'h4: y = 4'h9;
            4'h5: y = 4'h0;
            4'h6: y = 4'hA;
            4'h7: y = 4'hD;
            4'h8: y = 4'h3;
            4'h9: y = 4'hE;
            4'hA: y = 4'hF;
            4'hB: y = 4'h8;
            4'hC: y = 4'h4;
            4'hD: y = 4'h7;
            4'hE: y = 4'h1;
            default: y = 4'h2;
        endcase
        return y;
    endfunction

endpackage

// File: rtl/lwc_sub_layer.sv
module lwc_sub_layer
    import lwc_pkg::*;
#(
    parameter int N = NIBS
) (
    input  logic [N*NIB_W-1:0] din,
    output logic [N*NIB_W-1:0] dout
);
    for (genvar g = 0; g < N; g++) begin : g_nib
        assign dout[g*NIB_W +: NIB_W] = sub4(din[g*NIB_W +: NIB_W]);
    end
endmodule

// File: rtl/lwc_perm_layer.sv
module lwc_perm_layer #(
    parameter int W = 64
) (
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    localparam int Q = W / 4;
    localparam int M = W - 1;

    for (genvar g = 0; g < M; g++) begin : g_bit
        assign dout[(g * Q) % M] = din[g];
    end
    assign dout[M] = din[M];
endmodule

// File: rtl/lwc_round.sv
module lwc_round
    import lwc_pkg::*;
(
    input  logic [BLK_W-1:0] state_in,
    input  logic [BLK_W-1:0] round_key,
    output logic [BLK_W-1:0] state_out
);
    logic [BLK_W-1:0] mixed;
    logic [BLK_W-1:0] subbed;

    assign mixed = state_in ^ round_key;

    lwc_sub_layer #(.N(NIBS)) u_sub (
        .din  (mixed),
        .dout (subbed)
    );

    lwc_perm_layer #(.W(BLK_W)) u_perm (
        .din  (subbed),
        .dout (state_out)
    );
endmodule

// File: rtl/lwc_key_step.sv
module lwc_key_step
    import lwc_pkg::*;
#(
    parameter int CNT_W = 5,
    parameter int ROT   = 61,
    parameter int RC_LO = 15
) (
    input  logic [KEY_W-1:0] key_in,
    input  logic [CNT_W-1:0] rc,
    output logic [KEY_W-1:0] key_out
);
    localparam int DOWN = KEY_W - ROT;

    logic [KEY_W-1:0] rot;

    always_comb begin
        rot = {key_in[DOWN-1:0], key_in[KEY_W-1:DOWN]};
        rot[KEY_W-1 -: NIB_W] = sub4(rot[KEY_W-1 -: NIB_W]);
        rot[RC_LO +: CNT_W] = rot[RC_LO +: CNT_W] ^ rc;
        key_out = rot;
    end
endmodule

// File: rtl/lwc64_encrypt.sv
module lwc64_encrypt
    import lwc_pkg::*;
#(
    parameter int ROUNDS = 31,
    parameter int CNT_W  = $clog2(ROUNDS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [BLK_W-1:0] plain_in,
    input  logic [KEY_W-1:0] key_in,
    output logic             busy,
    output logic             done,
    output logic [BLK_W-1:0] cipher_out
);
    localparam logic [CNT_W-1:0] RC_FIRST = CNT_W'(1);
    localparam logic [CNT_W-1:0] RC_LAST  = CNT_W'(ROUNDS);

    typedef struct packed {
        phase_e           phase;
        logic [BLK_W-1:0] state;
        logic [KEY_W-1:0] key;
        logic [CNT_W-1:0] rnd;
        logic [BLK_W-1:0] cipher;
        logic             done;
    } regs_t;

    regs_t r_d, r_q;

    logic             idle;
    logic [BLK_W-1:0] src_state;
    logic [KEY_W-1:0] src_key;
    logic [CNT_W-1:0] src_rc;
    logic [BLK_W-1:0] round_out;
    logic [KEY_W-1:0] key_next;

    // round-1 inputs come from the ports, later rounds from the registers
    assign idle      = (r_q.phase == PH_IDLE);
    assign src_state = idle ? plain_in : r_q.state;
    assign src_key   = idle ? key_in   : r_q.key;
    assign src_rc    = idle ? RC_FIRST : r_q.rnd;

    lwc_round u_round (
        .state_in  (src_state),
        .round_key (src_key[KEY_W-1:RK_LSB]),
        .state_out (round_out)
    );

    lwc_key_step #(.CNT_W(CNT_W)) u_kstep (
        .key_in  (src_key),
        .rc      (src_rc),
        .key_out (key_next)
    );

    always_comb begin
        r_d = r_q;
        case (r_q.phase)
            PH_IDLE: begin
                if (start) begin
                    r_d.phase = (RC_FIRST == RC_LAST) ? PH_FINAL : PH_RUN;
                    r_d.state = round_out;
                    r_d.key   = key_next;
                    r_d.rnd   = RC_FIRST + CNT_W'(1);
                    r_d.done  = 1'b0;
                end
            end
            PH_RUN: begin
                r_d.state = round_out;
                r_d.key   = key_next;
                r_d.rnd   = r_q.rnd + CNT_W'(1);
                if (r_q.rnd == RC_LAST) begin
                    r_d.phase = PH_FINAL;
                end
            end
            PH_FINAL: begin
                r_d.cipher = r_q.state ^ r_q.key[KEY_W-1:RK_LSB];
                r_d.done   = 1'b1;
                r_d.phase  = PH_IDLE;
            end
            default: begin
                r_d.phase = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{phase: PH_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign busy       = !idle;
    assign done       = r_q.done;
    assign cipher_out = r_q.cipher;
endmodule

// File: rtl/lwc64_encrypt_chk.sv
module lwc64_encrypt_chk #(
    parameter int ROUNDS = 31,
    parameter int BLK_W  = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic [BLK_W-1:0] cipher_out
);
    localparam int BW = $clog2(ROUNDS + 2);

    logic [BW-1:0] busy_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    busy_run <= '0;
        else if (busy) busy_run <= busy_run + BW'(1);
        else           busy_run <= '0;
    end

    // R1
    reset_idle_chk: assert property (@(posedge clk) !rst_n |=> (!busy && !done) || !rst_n);

    // R2
    start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && !done));

    // R3
    busy_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (busy_run < BW'(ROUNDS)));

    // R3
    fall_gives_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && busy_run == BW'(ROUNDS - 1)) |=> (!busy && done));

    // R3
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    // R9
    start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && busy_run < BW'(ROUNDS - 1)) |=> busy);

    // R10
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(cipher_out)));

    // R11
    out_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cipher_out) |-> $rose(done));
endmodule

bind lwc64_encrypt lwc64_encrypt_chk #(.ROUNDS(ROUNDS), .BLK_W(lwc_pkg::BLK_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .busy       (busy),
    .done       (done),
    .cipher_out (cipher_out)
);

// File: tb/lwc64_encrypt_test.sv
`timescale 1ns/1ps
module lwc64_encrypt_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [63:0] plain_in = '0;
    logic [79:0] key_in = '0;
    logic        busy, done;
    logic [63:0] cipher_out;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    lwc64_encrypt uut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .plain_in(plain_in), .key_in(key_in),
        .busy(busy), .done(done), .cipher_out(cipher_out)
    );

    localparam logic [3:0] SB [16] = '{4'hC, 4'h5, 4'h6, 4'hB, 4'h9, 4'h0, 4'hA, 4'hD,
                                       4'h3, 4'hE, 4'hF, 4'h8, 4'h4, 4'h7, 4'h1, 4'h2};

    function automatic logic [63:0] model(input logic [63:0] pt, input logic [79:0] k);
        logic [63:0] s, t;
        logic [79:0] kr;
        s  = pt;
        kr = k;
        for (int r = 1; r <= 31; r++) begin
            s = s ^ kr[79:16];
            for (int n = 0; n < 16; n++) s[4*n +: 4] = SB[s[4*n +: 4]];
            t = '0;
            for (int i = 0; i < 64; i++) t[(i == 63) ? 63 : ((i * 16) % 63)] = s[i];
            s  = t;
            kr = {kr[18:0], kr[79:19]};
            kr[79:76] = SB[kr[79:76]];
            kr[19:15] = kr[19:15] ^ 5'(r);
        end
        return s ^ kr[79:16];
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // full block; optional intrusion pulse at busy cycle 'poke' (0 = none)
    task automatic run_block(input logic [63:0] pt, input logic [79:0] k,
                             input int poke, input string req);
        logic [63:0] exp;
        exp = model(pt, k);
        @(negedge clk);
        plain_in = pt; key_in = k; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        plain_in = ~pt; key_in = ~k;
        chk({req, "/R2 busy"}, 64'(busy), 64'd1);
        chk({req, "/R2 done clr"}, 64'(done), 64'd0);
        for (int c = 1; c < 31; c++) begin
            if (c == poke) start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        chk({req, "/R3 not yet"}, {62'd0, busy, done}, 64'd2);
        @(negedge clk);
        chk({req, "/R3 done"}, {62'd0, busy, done}, 64'd1);
        chk({req, "/R4 cipher"}, cipher_out, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [63:0] prev;
        void'($urandom(32'd12345));
        repeat (3) @(negedge clk);
        // R1
        chk("R1 reset", {61'd0, busy, done, |cipher_out}, 64'd0);
        rst_n = 1'b1;
        start = 1'b0;
        @(negedge clk);
        chk("R1 after release", {61'd0, busy, done, |cipher_out}, 64'd0);

        // R8 published vectors
        run_block(64'h0, 80'h0, 0, "R8a");
        chk("R8 zero vector", cipher_out, 64'h5579C1387B228445);
        run_block(64'h0, {80{1'b1}}, 0, "R8b");
        chk("R8 ones key", cipher_out, 64'hE72C46C0F5945049);
        // R5 R6 R7 covered by model on distinctive patterns
        run_block({64{1'b1}}, 80'h0, 0, "R6");
        run_block(64'h0123456789ABCDEF, 80'h0, 0, "R7");
        run_block(64'h0, 80'h80000000000000000001, 0, "R5");

        // R10 hold
        prev = cipher_out;
        repeat (7) @(negedge clk);
        chk("R10 done held", 64'(done), 64'd1);
        chk("R10 cipher held", cipher_out, prev);

        // R9 start while busy, first / middle / last busy cycle
        run_block(64'hDEADBEEFCAFEF00D, 80'h0F1E2D3C4B5A69788796, 1, "R9 first");
        run_block(64'h1122334455667788, 80'hFFEEDDCCBBAA99887766, 15, "R9 mid");
        run_block(64'hA5A5A5A55A5A5A5A, 80'h13579BDF02468ACE1357, 30, "R9 last");

        // R11 back-to-back random blocks, cipher unchanged while busy
        for (int b = 0; b < 10; b++) begin
            logic [63:0] p;
            logic [79:0] k;
            p = {$urandom, $urandom};
            k = {16'($urandom), $urandom, $urandom};
            prev = cipher_out;
            @(negedge clk);
            plain_in = p; key_in = k; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            repeat (15) @(negedge clk);
            chk("R11 stable while busy", cipher_out, prev);
            repeat (16) @(negedge clk);
            chk("R4 random", cipher_out, model(p, k));
            chk("R3 random done", {62'd0, busy, done}, 64'd1);
        end

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule